// File: doc/BRIEF.md
# Program Memory Loader

This block lets a host fill a processor's instruction store one 32-bit word at a time. The host writes words to a single data location. Each accepted word goes into a 256-entry program memory at the address held by an 8-bit load pointer. The pointer then moves on by one, so a whole program can be streamed in with repeated writes to the same location.

The same pointer is the address field of the run-control register. Writing that field sets where the next upload, or the next program run, starts. Reading it back gives the address where execution stopped. While the processor is running, the memory must not change under it. Data writes in that state are dropped without any indication.

The block drives a registered write strobe, address and data to an external memory array. It does not decode instructions, and it does not model the power-up contents of the memory.

Top module: `prog_loader`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `progAddr` is 0 and `memWe` is 0.
- R2: A data write accepted on a clock edge (`wordWrEn`=1, `runActive`=0) raises `memWe` for exactly one cycle after that edge. In that cycle, `memAddr` equals the pointer value before the edge and `memData` equals the written word.
- R3: After an accepted data write with no control write on the same edge, `progAddr` is one higher than before.
- R4: The pointer wraps from 255 to 0. A word written at 255 is stored at 255, and the next word goes to 0.
- R5: While `runActive`=1, data writes have no effect. `memWe` stays 0 and `progAddr` keeps its value.
- R6: A control write (`ctlWrEn`=1) loads `ctlAddr` into the pointer, which shows on `progAddr` one cycle later. This works whatever the value of `runActive`.
- R7: When a control write and an accepted data write share an edge, the pointer takes `ctlAddr`. The word is still stored at the pointer value from before that edge.
- R8: With no data write, `memWe` is 0. With neither kind of write, `progAddr` is unchanged.
- R9: Data writes on consecutive cycles store their words at consecutive addresses, one strobe per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| runActive | input | 1 | Processor run flag; 1 blocks data writes |
| ctlWrEn | input | 1 | Host write to the control register's address field |
| ctlAddr | input | 8 | New pointer value carried by the control write |
| wordWrEn | input | 1 | Host write to the program data location |
| wordIn | input | 32 | Instruction word carried by the data write |
| progAddr | output | 8 | Current pointer, read back through the control register |
| memWe | output | 1 | Program memory write strobe |
| memAddr | output | 8 | Program memory write address |
| memData | output | 32 | Program memory write data |

## Verification
A pointer that goes wrong inside the block shows up on `progAddr` on the very next cycle. It also shows up on `memAddr` with the next accepted word, so the bench compares both against its model on every clock. A wrong acceptance decision shows up one cycle after the write, either as a strobe that should not be there or as a strobe that is missing. Wrap and collision cases are driven on purpose, because a fault in those paths stays hidden until the pointer reaches 255 or both writes land on the same edge.

// File: rtl/prog_loader_pkg.sv
package prog_loader_pkg;
  typedef struct packed {
    logic store;   // write the word to memory at the current pointer
    logic advance; // step the pointer by one
    logic load;    // replace the pointer with the control value
  } loaderStrobes_t;
endpackage

// File: rtl/prog_loader_ctrl.sv
module prog_loader_ctrl
  import prog_loader_pkg::*;
(
  input  logic           runActive,
  input  logic           ctlWrEn,
  input  logic           wordWrEn,
  output loaderStrobes_t strobes
);
  logic accepted;

  always_comb begin
    accepted        = wordWrEn && !runActive;
    strobes.store   = accepted;
    // A control write takes priority over the automatic step.
    strobes.load    = ctlWrEn;
    strobes.advance = accepted && !ctlWrEn;
  end
endmodule

// File: rtl/prog_loader_dp.sv
module prog_loader_dp
  import prog_loader_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  loaderStrobes_t    strobes,
  input  logic [ADDR_W-1:0] ctlAddr,
  input  logic [DATA_W-1:0] wordIn,
  output logic [ADDR_W-1:0] progAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  localparam logic [ADDR_W-1:0] PTR_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] ptrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strobes.load) begin
      ptrQ <= ctlAddr;
    end else if (strobes.advance) begin
      ptrQ <= ptrQ + PTR_STEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe <= strobes.store;
      if (strobes.store) begin
        memAddr <= ptrQ;
        memData <= wordIn;
      end
    end
  end

  assign progAddr = ptrQ;
endmodule

// File: rtl/prog_loader.sv
module prog_loader
  import prog_loader_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runActive,
  input  logic              ctlWrEn,
  input  logic [ADDR_W-1:0] ctlAddr,
  input  logic              wordWrEn,
  input  logic [DATA_W-1:0] wordIn,
  output logic [ADDR_W-1:0] progAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  loaderStrobes_t strobes;

  prog_loader_ctrl u_ctrl (
    .runActive (runActive),
    .ctlWrEn   (ctlWrEn),
    .wordWrEn  (wordWrEn),
    .strobes   (strobes)
  );

  prog_loader_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .ctlAddr  (ctlAddr),
    .wordIn   (wordIn),
    .progAddr (progAddr),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memData  (memData)
  );
endmodule

// File: rtl/prog_loader_chk.sv
module prog_loader_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              runActive,
  input logic              ctlWrEn,
  input logic [ADDR_W-1:0] ctlAddr,
  input logic              wordWrEn,
  input logic [DATA_W-1:0] wordIn,
  input logic [ADDR_W-1:0] progAddr,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData
);
  always_comb begin
    if (!rstN) begin
      p_reset_state_r1: assert (progAddr == '0 && !memWe);
    end
  end

  p_store_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wordWrEn && !runActive) |=>
      (memWe && memAddr == $past(progAddr) && memData == $past(wordIn)));

  p_step_pointer_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wordWrEn && !runActive && !ctlWrEn) |=>
      (progAddr == ADDR_W'($past(progAddr) + 1'b1)));

  p_blocked_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wordWrEn && runActive && !ctlWrEn) |=> (!memWe && $stable(progAddr)));

  p_ctl_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> (progAddr == $past(ctlAddr)));

  p_idle_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wordWrEn |=> !memWe);

  p_idle_pointer_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!wordWrEn && !ctlWrEn) |=> $stable(progAddr));
endmodule

bind prog_loader prog_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_prog_loader.sv
module sim_prog_loader;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runActive = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [7:0]  ctlAddr = '0;
  logic        wordWrEn = 1'b0;
  logic [31:0] wordIn = '0;
  logic [7:0]  progAddr;
  logic        memWe;
  logic [7:0]  memAddr;
  logic [31:0] memData;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // behavioural reference state
  int mPtr = 0;
  bit mWe = 0;
  int mAddr = 0;
  longint mData = 0;

  prog_loader u0 (
    .clk(clk), .rstN(rstN), .runActive(runActive), .ctlWrEn(ctlWrEn),
    .ctlAddr(ctlAddr), .wordWrEn(wordWrEn), .wordIn(wordIn),
    .progAddr(progAddr), .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference model, updated from the inputs seen at each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPtr = 0; mWe = 0; mAddr = 0; mData = 0;
    end else begin
      bit acc;
      acc = wordWrEn && !runActive;
      mWe = acc;
      if (acc) begin
        mAddr = mPtr;
        mData = longint'(wordIn);
      end
      if (ctlWrEn) mPtr = int'(ctlAddr);
      else if (acc) mPtr = (mPtr + 1) % 256;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN) begin
      check(curReq, "progAddr", longint'(progAddr), longint'(mPtr));
      check(curReq, "memWe", longint'(memWe), longint'(mWe));
      check(curReq, "memAddr", longint'(memAddr), longint'(mAddr));
      check(curReq, "memData", longint'(memData), mData);
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  // apply one cycle of stimulus after a falling edge
  task automatic drive(bit c, logic [7:0] ca, bit w, logic [31:0] d, bit r);
    @(negedge clk);
    #1;
    ctlWrEn = c; ctlAddr = ca; wordWrEn = w; wordIn = d; runActive = r;
  endtask

  initial begin
    // R1: reset state while held and just after release
    repeat (3) @(posedge clk);
    #1;
    check("R1", "progAddr in reset", longint'(progAddr), 0);
    check("R1", "memWe in reset", longint'(memWe), 0);
    @(negedge clk);
    rstN = 1'b1;
    drive(0, 8'h00, 0, 32'h0, 0);

    curReq = "R2";
    drive(0, 8'h00, 1, 32'hCAFE0001, 0);
    drive(0, 8'h00, 0, 32'h0, 0);
    drive(0, 8'h00, 0, 32'h0, 0);

    curReq = "R3";
    for (int i = 0; i < 4; i++) begin
      drive(0, 8'h00, 1, 32'h1000 + i, 0);
      drive(0, 8'h00, 0, 32'h0, 0);
    end

    curReq = "R6";
    drive(1, 8'hFD, 0, 32'h0, 0);
    drive(0, 8'h00, 0, 32'h0, 0);

    curReq = "R4";
    for (int i = 0; i < 5; i++) drive(0, 8'h00, 1, 32'hA0A00000 + i, 0);
    drive(0, 8'h00, 0, 32'h0, 0);

    curReq = "R5";
    for (int i = 0; i < 4; i++) drive(0, 8'h00, 1, 32'hDEAD0000 + i, 1);
    drive(0, 8'h00, 0, 32'h0, 1);

    curReq = "R6";
    drive(1, 8'h40, 1, 32'hBAD00000, 1);
    drive(0, 8'h00, 0, 32'h0, 0);
    drive(1, 8'h10, 0, 32'h0, 0);
    drive(0, 8'h00, 0, 32'h0, 0);

    curReq = "R7";
    drive(1, 8'h80, 1, 32'h77777777, 0);
    drive(0, 8'h00, 1, 32'h88888888, 0);
    drive(1, 8'hFF, 1, 32'h99999999, 0);
    drive(0, 8'h00, 1, 32'hAAAAAAAA, 0);
    drive(0, 8'h00, 0, 32'h0, 0);

    curReq = "R8";
    repeat (4) drive(0, 8'h55, 0, 32'h12345678, 0);
    repeat (2) drive(0, 8'h55, 0, 32'h12345678, 1);

    curReq = "R9";
    drive(1, 8'hF0, 0, 32'h0, 0);
    for (int i = 0; i < 40; i++) drive(0, 8'h00, 1, $urandom, 0);
    for (int i = 0; i < 60; i++)
      drive(($urandom % 7) == 0, 8'($urandom), ($urandom % 3) != 0,
            $urandom, ($urandom % 4) == 0);
    drive(0, 8'h00, 0, 32'h0, 0);
    drive(0, 8'h00, 0, 32'h0, 0);
    @(negedge clk);
    #1;
    finishRun();
  end
endmodule